// File: doc/BRIEF.md
# Encrypted Configuration Access Policy Controller

This block decides, one request at a time, whether a configuration-security operation on a programmable device may go ahead. It keeps track of three things: whether a 256-bit decryption key is loaded, whether key-access mode is open, and whether the device currently holds an encrypted configuration. Requests arrive as a one-cycle strobe with an opcode and qualifiers. The opcodes are key-mode entry, key write, key-mode exit, configuration load, readback and full reset. The qualifiers are the encrypted and partial flags, the source port and the readback security setting.

Every request produces exactly one grant or reject pulse in the next cycle. A reject also raises a sticky error flag. The key register can only be written; its contents go solely to the decryption datapath on `cipher_key`, and no request returns them. The synchronous `rst` input acts as a power-on event. It keeps the key only while `batt_ok` is high.

Top module: `cfgsec_policy_ctrl`

## Requirements
- R1: Each cycle with `req_valid` high yields exactly one of `grant`/`reject` high in the next cycle, for one cycle. A cycle with `req_valid` low yields neither. Opcodes are 0 key-enter, 1 key-write, 2 key-exit, 3 load, 4 readback, 5 full-reset. Codes 6 and 7 are rejected.
- R2: Every reject sets `err` in the same cycle as the reject pulse. `err` stays high until a granted full-reset request or `rst`.
- R3: Key-enter is granted only when `req_port` is 2 (JTAG). Ports are 0 serial, 1 parallel, 2 JTAG, 3 internal. A granted key-enter does all of the following:
  - clears the key and `key_valid`;
  - clears the encrypted-configuration state;
  - opens key mode;
  - pulses `key_clear` together with the grant.
- R4: Key-write and key-exit are granted only while key mode is open. A granted key-write stores `key_in` and sets `key_valid`. A rejected key-write leaves the key unchanged.
- R5: An encrypted load (`req_enc`=1) is rejected while `key_valid` is low.
- R6: An encrypted load with `req_partial`=1 is rejected from ports 0 to 2. From port 3 it is granted when the key is valid.
- R7: After a granted encrypted load, every plain load is rejected until a full reset. Further encrypted loads are granted.
- R8: A plain load is granted when no encrypted configuration is held, even with a key stored. The key and `key_valid` stay unchanged.
- R9: While an encrypted configuration is held, readback from ports 0 to 2 is rejected even with `rb_allow`=1. Readback from port 3 is always granted.
- R10: With no encrypted configuration held, readback from ports 0 to 2 is granted exactly when `rb_allow` is 1.
- R11: Full-reset is always granted. It clears the encrypted state, key mode and `err`, and it keeps the key and `key_valid`.
- R12: `rst` clears the encrypted state, key mode, `err` and all pulses. The key and `key_valid` survive if `batt_ok` is 1; otherwise both are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous power-on reset, active high |
| batt_ok | input | 1 | Backup supply good, sampled during `rst` |
| req_valid | input | 1 | Request strobe |
| req_op | input | 3 | Request opcode |
| req_enc | input | 1 | Load is encrypted |
| req_partial | input | 1 | Load is partial |
| req_port | input | 2 | Port the request came through |
| rb_allow | input | 1 | Readback security setting permits readback |
| key_in | input | 256 | Key value for key-write |
| grant | output | 1 | Request granted pulse |
| reject | output | 1 | Request rejected pulse |
| err | output | 1 | Sticky error flag |
| key_valid | output | 1 | A key is stored |
| key_clear | output | 1 | Key wipe pulse |
| cipher_key | output | 256 | Stored key, to the decryption datapath only |

## Verification
The bench checks that the encrypted lock-out is driven by history rather than by the current request. After an encrypted load, a plain load must fail and a second encrypted load must pass; a design keyed only on `key_valid` would accept the plain load. It then checks that external readback is refused even with the setting permissive, while internal readback passes; a missing lock would leak the configuration. It resets with the backup supply both up and down: a design that kept the key unconditionally, or wiped it on every reset, would show the wrong `key_valid` and `cipher_key`. Finally it checks that a key-write outside key mode and a key-enter over a non-JTAG port fail without touching the stored key.

// File: rtl/cfgsec_pkg.sv
package cfgsec_pkg;

    localparam int KEY_W  = 256;
    localparam int OP_W   = 3;
    localparam int PORT_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_KEY_ENTER = 3'd0,
        OP_KEY_WRITE = 3'd1,
        OP_KEY_EXIT  = 3'd2,
        OP_LOAD      = 3'd3,
        OP_READBACK  = 3'd4,
        OP_FULL_RST  = 3'd5
    } op_e;

    typedef enum logic [PORT_W-1:0] {
        PORT_SERIAL   = 2'd0,
        PORT_PARALLEL = 2'd1,
        PORT_JTAG     = 2'd2,
        PORT_INTERNAL = 2'd3
    } port_e;

    typedef struct packed {
        logic enc_cfg;
        logic key_mode;
        logic err;
    } policy_state_t;

    typedef struct packed {
        logic grant;
        logic reject;
        logic wipe_key;
        logic store_key;
        logic set_enc;
        logic clr_enc;
        logic open_kmode;
        logic close_kmode;
        logic clr_err;
    } verdict_t;

    function automatic logic is_external(input logic [PORT_W-1:0] p);
        return p != PORT_INTERNAL;
    endfunction

endpackage

// File: rtl/cfgsec_key_store.sv
module cfgsec_key_store
    import cfgsec_pkg::*;
#(
    parameter int W = KEY_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         batt_ok,
    input  logic         wipe,
    input  logic         store,
    input  logic [W-1:0] key_in,
    output logic [W-1:0] key_q,
    output logic         key_valid
);
    // Write-only key register; retained through rst while backup supply holds.
    always_ff @(posedge clk) begin
        if (rst) begin
            if (!batt_ok) begin
                key_q     <= '0;
                key_valid <= 1'b0;
            end
        end else if (wipe) begin
            key_q     <= '0;
            key_valid <= 1'b0;
        end else if (store) begin
            key_q     <= key_in;
            key_valid <= 1'b1;
        end
    end
endmodule

// File: rtl/cfgsec_decide.sv
module cfgsec_decide
    import cfgsec_pkg::*;
(
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic              req_enc,
    input  logic              req_partial,
    input  logic [PORT_W-1:0] req_port,
    input  logic              rb_allow,
    input  logic              key_valid,
    input  policy_state_t     st,
    output verdict_t          v
);
    logic ok;
    logic ext;

    always_comb begin
        ext = is_external(req_port);
        ok  = 1'b0;
        case (req_op)
            OP_KEY_ENTER: ok = (req_port == PORT_JTAG);
            OP_KEY_WRITE: ok = st.key_mode;
            OP_KEY_EXIT:  ok = st.key_mode;
            OP_LOAD: begin
                if (req_enc) ok = key_valid && !(req_partial && ext);
                else         ok = !st.enc_cfg;
            end
            OP_READBACK:  ok = !ext || (!st.enc_cfg && rb_allow);
            OP_FULL_RST:  ok = 1'b1;
            default:      ok = 1'b0;
        endcase
    end

    always_comb begin
        v             = '0;
        v.grant       = req_valid && ok;
        v.reject      = req_valid && !ok;
        v.wipe_key    = v.grant && (req_op == OP_KEY_ENTER);
        v.store_key   = v.grant && (req_op == OP_KEY_WRITE);
        v.open_kmode  = v.wipe_key;
        v.close_kmode = v.grant && ((req_op == OP_KEY_EXIT) || (req_op == OP_FULL_RST));
        v.set_enc     = v.grant && (req_op == OP_LOAD) && req_enc;
        v.clr_enc     = v.wipe_key || (v.grant && (req_op == OP_FULL_RST));
        v.clr_err     = v.grant && (req_op == OP_FULL_RST);
    end
endmodule

// File: rtl/cfgsec_policy_ctrl.sv
module cfgsec_policy_ctrl
    import cfgsec_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              batt_ok,
    input  logic              req_valid,
    input  logic [OP_W-1:0]   req_op,
    input  logic              req_enc,
    input  logic              req_partial,
    input  logic [PORT_W-1:0] req_port,
    input  logic              rb_allow,
    input  logic [KEY_W-1:0]  key_in,
    output logic              grant,
    output logic              reject,
    output logic              err,
    output logic              key_valid,
    output logic              key_clear,
    output logic [KEY_W-1:0]  cipher_key
);
    policy_state_t st_q;
    verdict_t      v;

    cfgsec_decide decide_i (
        .req_valid  (req_valid),
        .req_op     (req_op),
        .req_enc    (req_enc),
        .req_partial(req_partial),
        .req_port   (req_port),
        .rb_allow   (rb_allow),
        .key_valid  (key_valid),
        .st         (st_q),
        .v          (v)
    );

    cfgsec_key_store #(.W(KEY_W)) key_i (
        .clk      (clk),
        .rst      (rst),
        .batt_ok  (batt_ok),
        .wipe     (v.wipe_key),
        .store    (v.store_key),
        .key_in   (key_in),
        .key_q    (cipher_key),
        .key_valid(key_valid)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= '0;
            grant     <= 1'b0;
            reject    <= 1'b0;
            key_clear <= 1'b0;
        end else begin
            grant     <= v.grant;
            reject    <= v.reject;
            key_clear <= v.wipe_key;
            if (v.clr_enc)          st_q.enc_cfg <= 1'b0;
            else if (v.set_enc)     st_q.enc_cfg <= 1'b1;
            if (v.close_kmode)      st_q.key_mode <= 1'b0;
            else if (v.open_kmode)  st_q.key_mode <= 1'b1;
            if (v.clr_err)          st_q.err <= 1'b0;
            else if (v.reject)      st_q.err <= 1'b1;
        end
    end

    assign err = st_q.err;
endmodule

// File: rtl/cfgsec_policy_ctrl_chk.sv
module cfgsec_policy_ctrl_chk
    import cfgsec_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic [OP_W-1:0]   req_op,
    input logic              req_enc,
    input logic [PORT_W-1:0] req_port,
    input logic              grant,
    input logic              reject,
    input logic              err,
    input logic              key_valid,
    input logic              key_clear,
    input logic              enc_cfg
);
    assert_one_verdict_R1: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> (grant ^ reject));
    assert_no_spurious_R1: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!grant && !reject));
    assert_reject_sets_err_R2: assert property (@(posedge clk) disable iff (rst)
        reject |-> err);
    assert_wipe_drops_key_R3: assert property (@(posedge clk) disable iff (rst)
        key_clear |-> !key_valid);
    assert_enc_needs_key_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_LOAD && req_enc && !key_valid) |=> reject);
    assert_plain_locked_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_LOAD && !req_enc && enc_cfg) |=> reject);
    assert_ext_rb_denied_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_READBACK && req_port != PORT_INTERNAL && enc_cfg) |=> reject);
    assert_int_rb_granted_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == OP_READBACK && req_port == PORT_INTERNAL) |=> grant);
endmodule

bind cfgsec_policy_ctrl cfgsec_policy_ctrl_chk chk_i (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_op   (req_op),
    .req_enc  (req_enc),
    .req_port (req_port),
    .grant    (grant),
    .reject   (reject),
    .err      (err),
    .key_valid(key_valid),
    .key_clear(key_clear),
    .enc_cfg  (st_q.enc_cfg)
);

// File: tb/cfgsec_policy_ctrl_tb_top.sv
`timescale 1ns/1ps
module cfgsec_policy_ctrl_tb_top;
    logic         clk = 1'b0;
    logic         rst = 1'b0;
    logic         batt_ok = 1'b0;
    logic         req_valid = 1'b0;
    logic [2:0]   req_op = '0;
    logic         req_enc = 1'b0;
    logic         req_partial = 1'b0;
    logic [1:0]   req_port = '0;
    logic         rb_allow = 1'b0;
    logic [255:0] key_in = '0;
    logic         grant, reject, err, key_valid, key_clear;
    logic [255:0] cipher_key;

    always #2 clk = ~clk;

    cfgsec_policy_ctrl dut_i (
        .clk(clk), .rst(rst), .batt_ok(batt_ok), .req_valid(req_valid),
        .req_op(req_op), .req_enc(req_enc), .req_partial(req_partial),
        .req_port(req_port), .rb_allow(rb_allow), .key_in(key_in),
        .grant(grant), .reject(reject), .err(err), .key_valid(key_valid),
        .key_clear(key_clear), .cipher_key(cipher_key)
    );

    typedef struct packed {
        logic         g, r, e, kv, kc;
        logic [255:0] key;
    } exp_t;

    exp_t  exp_q[$];
    string tag_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    done     = 0;

    // reference state
    bit           m_keyv = 0, m_enc = 0, m_kmode = 0, m_err = 0;
    logic [255:0] m_key = '0;

    localparam logic [255:0] K1 = {8{32'hA5C3_1F07}};
    localparam logic [255:0] K2 = {8{32'h0BAD_F00D}};

    task automatic push(input bit g, input bit r, input bit kc, input string tag);
        exp_t x;
        x.g = g; x.r = r; x.e = m_err; x.kv = m_keyv; x.kc = kc; x.key = m_key;
        exp_q.push_back(x);
        tag_q.push_back(tag);
    endtask

    task automatic do_rst(input bit batt, input string tag);
        @(negedge clk);
        rst = 1; batt_ok = batt; req_valid = 0;
        if (!batt) begin m_keyv = 0; m_key = '0; end
        m_enc = 0; m_kmode = 0; m_err = 0;
        push(0, 0, 0, tag);
        @(negedge clk);
        rst = 0;
        push(0, 0, 0, tag);
    endtask

    task automatic step(input bit vld, input logic [2:0] op, input bit enc, input bit part,
                        input logic [1:0] port, input bit rba, input logic [255:0] k,
                        input string tag);
        bit ok, ext;
        @(negedge clk);
        req_valid = vld; req_op = op; req_enc = enc; req_partial = part;
        req_port = port; rb_allow = rba; key_in = k;
        ext = (port != 2'd3);
        case (op)
            3'd0: ok = (port == 2'd2);
            3'd1: ok = m_kmode;
            3'd2: ok = m_kmode;
            3'd3: ok = enc ? (m_keyv && !(part && ext)) : !m_enc;
            3'd4: ok = !ext || (!m_enc && rba);
            3'd5: ok = 1;
            default: ok = 0;
        endcase
        if (!vld) begin
            push(0, 0, 0, tag);
        end else begin
            if (!ok) m_err = 1;
            if (ok) begin
                case (op)
                    3'd0: begin m_key = '0; m_keyv = 0; m_enc = 0; m_kmode = 1; end
                    3'd1: begin m_key = k; m_keyv = 1; end
                    3'd2: m_kmode = 0;
                    3'd3: if (enc) m_enc = 1;
                    3'd5: begin m_enc = 0; m_kmode = 0; m_err = 0; end
                    default: ;
                endcase
            end
            push(ok, !ok, ok && op == 3'd0, tag);
        end
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                exp_t  x;
                string t;
                x = exp_q.pop_front();
                t = tag_q.pop_front();
                n_checks++;
                if ({grant, reject, err, key_valid, key_clear} !== {x.g, x.r, x.e, x.kv, x.kc}
                    || cipher_key !== x.key) begin
                    n_fail++;
                    $display("FAIL %s: got g/r/e/kv/kc=%b%b%b%b%b key=%h exp %b%b%b%b%b key=%h",
                             t, grant, reject, err, key_valid, key_clear, cipher_key,
                             x.g, x.r, x.e, x.kv, x.kc, x.key);
                end
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        do_rst(0, "R12 reset state, no backup");
        step(0, 0, 0, 0, 0, 0, '0, "R1 idle no pulse");
        step(1, 3'd7, 0, 0, 0, 0, '0, "R1 bad opcode");
        step(1, 3'd5, 0, 0, 0, 0, '0, "R11 full reset clears err");
        step(1, 3'd4, 0, 0, 0, 1, '0, "R10 ext readback allowed");
        step(1, 3'd4, 0, 0, 1, 0, '0, "R10 ext readback denied by setting");
        step(1, 3'd5, 0, 0, 2, 0, '0, "R2 err cleared by full reset");
        step(1, 3'd3, 1, 0, 0, 0, '0, "R5 enc load without key");
        step(1, 3'd0, 0, 0, 0, 0, '0, "R3 key enter on serial");
        step(1, 3'd1, 0, 0, 2, 0, K2, "R4 key write outside mode");
        step(1, 3'd5, 0, 0, 2, 0, '0, "R11 full reset");
        step(1, 3'd0, 0, 0, 2, 0, '0, "R3 key enter via jtag");
        step(1, 3'd1, 0, 0, 2, 0, K1, "R4 key write");
        step(1, 3'd2, 0, 0, 2, 0, '0, "R4 key exit");
        step(1, 3'd2, 0, 0, 2, 0, '0, "R4 key exit outside mode");
        step(1, 3'd5, 0, 0, 2, 0, '0, "R11 full reset");
        step(1, 3'd3, 0, 0, 1, 0, '0, "R8 plain load with key");
        step(1, 3'd4, 0, 0, 0, 1, '0, "R10 readback after plain load");
        step(1, 3'd3, 1, 1, 1, 0, '0, "R6 enc partial on external");
        step(1, 3'd5, 0, 0, 0, 0, '0, "R11 full reset");
        step(1, 3'd3, 1, 1, 3, 0, '0, "R6 enc partial on internal");
        step(1, 3'd3, 1, 0, 0, 0, '0, "R7 enc full load");
        step(1, 3'd3, 0, 0, 0, 0, '0, "R7 plain after enc");
        step(1, 3'd3, 1, 0, 1, 0, '0, "R7 enc again");
        step(1, 3'd4, 0, 0, 2, 1, '0, "R9 jtag readback after enc");
        step(1, 3'd4, 0, 0, 0, 1, '0, "R9 serial readback after enc");
        step(1, 3'd4, 0, 0, 3, 0, '0, "R9 internal readback after enc");
        step(1, 3'd5, 0, 0, 0, 0, '0, "R11 full reset keeps key");
        step(1, 3'd3, 0, 0, 0, 0, '0, "R11 plain load after full reset");
        step(1, 3'd3, 1, 0, 0, 0, '0, "R7 enc load before power reset");
        do_rst(1, "R12 reset with backup keeps key");
        step(1, 3'd3, 0, 0, 0, 0, '0, "R12 plain load after power reset");
        step(1, 3'd0, 0, 0, 2, 0, '0, "R3 key enter wipes stored key");
        step(1, 3'd1, 0, 0, 2, 0, K2, "R4 second key write");
        do_rst(0, "R12 reset without backup clears key");
        step(1, 3'd3, 1, 0, 0, 0, '0, "R5 enc load after key loss");
        step(0, 0, 0, 0, 0, 0, '0, "R1 final idle");
        @(negedge clk);
        @(negedge clk);
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule